// File: doc/BRIEF.md
# Sub-rate D-channel serial port

This block carries D-channel traffic between a byte-wide register port and the D-channel slot of a serial time-division frame. A single clock tick is one bit time. The frame pulse marks bit position 0 of a frame. The D-channel bits sit at fixed positions starting at `DPOS`. At the slow rate, each frame moves two bits of a byte, so a byte needs four frames. At the fast rate, each frame moves four bits, so a byte needs two frames. Bits travel least significant first in both directions.

Software writes the next transmit byte to the data address and reads the last received byte from the same address. A write takes effect at the next byte boundary, so the byte already on the line is never corrupted. When a byte boundary passes, the block pulls the active-low interrupt at the next frame pulse. The interrupt is released by any read or write of the data address, or by the frame pulse after that, whichever comes first.

Top module: `dchan_serial`

## Requirements
- R1: After reset `irq_n` is 1 and `sdo_oe` is 0 until a frame pulse arrives. The transmit byte is 8'hFF, so the first byte sent is all ones.
- R2: With control bit 0 at 0 (slow rate), `sdo_oe` is 1 at exactly frame positions DPOS and DPOS+1. At every other position `sdo_oe` is 0 and `sdo` is 1. The frame-pulse cycle is position 0.
- R3: With control bit 0 at 1 (fast rate), `sdo_oe` is 1 at exactly frame positions DPOS to DPOS+3.
- R4: Transmit bits leave least significant bit first. Bit D0 is in the first slot after a byte boundary, and the byte continues across consecutive frames.
- R5: Received slot bits are assembled D0 first. Once the eighth bit has arrived, a read of address 0x15 returns the whole byte.
- R6: A write to address 0x15 stores the next transmit byte. It does not change the bits of the byte currently on the line, and it is sent starting at the next byte boundary.
- R7: After a byte boundary, `irq_n` goes to 0 in the cycle after the next frame pulse.
- R8: A read or write of address 0x15 while `irq_n` is 0 returns `irq_n` to 1 on the next cycle.
- R9: If no such access occurs, the next frame pulse returns `irq_n` to 1, unless another byte boundary has passed since the previous pulse.
- R10: An access to any other address leaves `irq_n` unchanged.
- R11: Address 0x16 holds the rate control in bit 0. Writing it sets the rate, and reading it returns that bit in bit 0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| fp | input | 1 | Frame pulse, high for the position-0 cycle |
| sdi | input | 1 | Serial data from the frame |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when `rd_en` is low |
| sdo | output | 1 | Serial data to the frame |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| irq_n | output | 1 | Active-low byte interrupt |

## Verification
The assertions assume the following about the inputs:
- Frame pulses are single-cycle.
- Frames are long enough that a byte boundary never coincides with a pulse, which holds whenever DPOS is at least 1.
- Rate changes are made only at a byte boundary.

The stimulus meets these assumptions in three ways. It drives a fixed 12-cycle frame. It changes the rate only in the cycles after the last slot of a byte. It places every register access outside the frame-pulse cycle. Under these conditions the sweep covers every byte position at both rates, each way of releasing the interrupt, and writes that land in the middle of a byte.

// File: rtl/dchan_serial.sv
module dchan_serial #(
  parameter int CNT_W = 5,
  parameter int DPOS = 4,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'h15,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp,
  input  logic              sdi,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              irq_n
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] SLOT0 = CNT_W'(DPOS);

  logic [CNT_W-1:0] cnt, pos, off, nbits;
  logic [7:0] tx_hold, tx_shift, rx_shift, rx_data;
  logic [2:0] bidx;
  logic mode16, pend, slot, done, acc;

  assign pos   = fp ? '0 : ((cnt == CMAX) ? CMAX : cnt + 1'b1);
  assign off   = pos - SLOT0;
  assign nbits = mode16 ? CNT_W'(4) : CNT_W'(2);
  assign slot  = (pos >= SLOT0) && (off < nbits);
  assign done  = slot && (bidx == 3'd7);
  assign acc   = (wr_en || rd_en) && (addr == DATA_ADDR);

  assign sdo_oe = slot;
  assign sdo    = slot ? tx_shift[bidx] : 1'b1;

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (addr == DATA_ADDR) rdata = rx_data;
      else if (addr == CTRL_ADDR) rdata = {7'b0, mode16};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= CMAX;
      tx_hold  <= 8'hFF;
      tx_shift <= 8'hFF;
      rx_shift <= 8'h00;
      bidx     <= 3'd0;
      mode16   <= 1'b0;
      pend     <= 1'b0;
      irq_n    <= 1'b1;
    end else begin
      cnt <= pos;
      if (wr_en && addr == DATA_ADDR) tx_hold <= wdata;
      if (wr_en && addr == CTRL_ADDR) mode16 <= wdata[0];
      if (slot) begin
        bidx <= bidx + 3'd1;
        rx_shift[bidx] <= sdi;
      end
      if (done) begin
        tx_shift <= tx_hold;
        pend <= 1'b1;
      end
      if (fp) begin
        irq_n <= !pend;
        pend  <= 1'b0;
      end else if (acc) begin
        irq_n <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done) rx_data <= {sdi, rx_shift[6:0]};
  end

  a_r2_no_slot_at_fp: assert property (@(posedge clk) disable iff (!rst_n)
    fp |-> !sdo_oe);
  a_r7_irq_fall_after_fp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(fp));
  a_r8_r9_irq_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> ($past(fp) || $past(acc)));
  a_r8_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !fp) |=> irq_n);
  a_r6_shift_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> $stable(tx_shift));
  a_r4_index_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |=> $stable(bidx));
endmodule

// File: tb/dchan_serial_tb_top.sv
module dchan_serial_tb_top;
  localparam int FL = 12;
  localparam int DP = 4;
  localparam int NB = 32;
  localparam logic [4:0] DA = 5'h15;
  localparam logic [4:0] CA = 5'h16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, fp, sdi, wr_en, rd_en;
  logic [4:0] addr;
  logic [7:0] wdata, rdata;
  logic sdo, sdo_oe, irq_n;
  int total = 0, bad = 0;

  dchan_serial dut_i (.clk(clk), .rst_n(rst_n), .fp(fp), .sdi(sdi), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .sdo(sdo),
    .sdo_oe(sdo_oe), .irq_n(irq_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] txp(input int g);
    return (g == 0) ? 8'hFF : 8'((g * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] rxp(input int g);
    return 8'((g * 91 + 60) & 255);
  endfunction

  task automatic frame(input int g, input int fi, input int k, input bit last, input bit m16);
    logic [7:0] tb, rb;
    tb = txp(g);
    rb = rxp(g);
    for (int c = 0; c < FL; c++) begin
      int j;
      bit in_slot;
      @(negedge clk);
      fp = (c == 0); wr_en = 0; rd_en = 0; sdi = 0; addr = 5'h00; wdata = 8'h00;
      in_slot = (c >= DP) && (c < DP + k);
      j = fi * k + c - DP;
      if (in_slot) sdi = rb[j];
      if (c == 2 && fi == 0) begin rd_en = 1; addr = CA; end
      if (c == 2 && last) begin wr_en = 1; addr = DA; wdata = txp(g + 1); end
      if (c == 8 && fi == 0 && g > 0 && (g % 3) != 2) begin
        addr = DA;
        if (g % 2 == 1) begin wr_en = 1; wdata = txp(g + 1); end
        else rd_en = 1;
      end
      if (c == 9 && last) begin rd_en = 1; addr = DA; end
      if (c == 10 && last && g == 15) begin wr_en = 1; addr = CA; wdata = 8'h01; end
      #1;
      if (in_slot) begin
        chk(sdo_oe == 1'b1, (k == 2) ? "R2" : "R3", sdo_oe, 1);
        chk(sdo == tb[j], last ? "R6" : ((g == 0) ? "R1" : "R4"), sdo, tb[j]);
      end else begin
        chk(sdo_oe == 1'b0 && sdo == 1'b1, (k == 2) ? "R2" : "R3", {sdo_oe, sdo}, 1);
      end
      if (c == 1 && fi == 0) chk(irq_n == (g == 0), "R7", irq_n, (g == 0));
      if (c == 1 && fi == 1) chk(irq_n == 1'b1, "R9", irq_n, 1);
      if (c == 2 && fi == 0) chk(rdata == {7'b0, m16}, "R11", rdata, m16);
      if (c == 3 && fi == 0 && g > 0) chk(irq_n == 1'b0, "R10", irq_n, 0);
      if (c == 8 && fi == 0 && g > 0 && (g % 3) != 2 && (g % 2) == 0)
        chk(rdata == rxp(g - 1), "R5", rdata, rxp(g - 1));
      if (c == 9 && fi == 0 && g > 0 && (g % 3) != 2) chk(irq_n == 1'b1, "R8", irq_n, 1);
      if (c == 9 && last) chk(rdata == rb, "R5", rdata, rb);
    end
  endtask

  initial begin
    rst_n = 0; fp = 0; sdi = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #1;
      chk(irq_n == 1'b1 && sdo_oe == 1'b0, "R1", {irq_n, sdo_oe}, 2);
    end
    for (int g = 0; g < NB; g++) begin
      int k, nf;
      k = (g < 16) ? 2 : 4;
      nf = 8 / k;
      for (int fi = 0; fi < nf; fi++) frame(g, fi, k, fi == nf - 1, g >= 16);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule